// File: doc/BRIEF.md
# Switching-Order Rank Recorder

This block turns the order in which a set of decision lines go high into a rank per line. During a ramp phase, each line stays low until its own comparator trips. The first line to rise gets rank 0. Lines that rise later get higher ranks. For a distance-classifying array driven by a falling ramp, this order matches the order of the lines' distances, so the ranks sort the stored patterns by distance.

One shared rank counter feeds a cell per line. When one or more not-yet-ranked lines rise in a clock cycle, each of them copies the current counter value into its own cell. The counter then steps by one. Lines that rise together therefore share a rank, and the next distinct rise takes the next value (dense ranking).

A start strobe opens a new run. It clears the counter, every cell and every valid flag. The lines are asynchronous to the clock, so each one passes through a two-flop synchronizer and a rising-edge detector before it is used.

Top module: `rank_recorder`

## Requirements
- R1: While reset is asserted and after it is released with no switching, every valid bit is 0, every rank field is 0 and `all_ranked_o` is 0.
- R2: A 0-to-1 transition of `sw_i[i]` that is sampled at clock edge k makes `valid_o[i]` read 1 after edge k+2. From then on, `rank_o[i*RANK_W +: RANK_W]` holds the counter value of that cycle. A 1-to-0 transition captures nothing, and a 1-cycle-wide pulse counts as a switch.
- R3: The counter starts at 0 after reset or start. It advances by exactly one at the end of each cycle in which at least one unranked line captures, and it never goes above N_LINES-1.
- R4: Lines whose rising edges are detected in the same cycle receive identical ranks. The next line to rise afterwards receives that rank plus one.
- R5: Once a line is ranked, later transitions of that line leave its rank and valid bit unchanged and do not advance the counter.
- R6: A cycle with `start_i` high clears the counter, all ranks and all valid bits, and edges in that cycle are not captured. A line already high across the start is treated as switching in the first cycle after the start.
- R7: `all_ranked_o` is 1 exactly when every bit of `valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start of a new ranking run (clears all state) |
| sw_i | input | N_LINES | Asynchronous decision lines, one per neuron |
| rank_o | output | N_LINES*RANK_W | Rank field per line, line i at bits i*RANK_W upward |
| valid_o | output | N_LINES | Line i has been ranked in this run |
| all_ranked_o | output | 1 | Every line has been ranked |

## Verification
The bench tries four input patterns:
- Lines rising one at a time, in a scrambled order, show whether the ranks follow the switching order rather than the line index.
- Groups rising together show that ties share a rank and that the counter then steps only once.
- A ranked line that drops and rises again shows that a cell cannot be rewritten and that the counter ignores the repeat.
- A start issued while every line is already high, followed by a single-cycle pulse, separates the start-clearing rule from the synchronizer's edge handling.

// File: rtl/rank_rec_pkg.sv
package rank_rec_pkg;

  // Width of a rank value for a given number of lines (at least one bit).
  function automatic int unsigned rank_width(input int unsigned n_lines);
    return (n_lines < 2) ? 1 : $clog2(n_lines);
  endfunction

endpackage

// File: rtl/rank_line_sync.sv
module rank_line_sync #(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear_i,
  input  logic [N_LINES-1:0] line_i,
  output logic [N_LINES-1:0] rise_o
);

  logic [N_LINES-1:0] meta_q, meta_d;
  logic [N_LINES-1:0] stab_q, stab_d;
  logic [N_LINES-1:0] hist_q, hist_d;

  // Next state: two-flop synchronizer plus one history stage.
  // A clear empties the history so lines held high are seen as new.
  always_comb begin
    meta_d = line_i;
    stab_d = meta_q;
    hist_d = clear_i ? '0 : stab_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
      hist_q <= hist_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : g_edge
      assign rise_o[g] = stab_q[g] & ~hist_q[g];
    end
  endgenerate

  // A rise seen now must be remembered in the history unless a clear intervenes.
  assert_rise_consumed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o[0] && !clear_i) |=> hist_q[0]);

endmodule

// File: rtl/rank_counter.sv
module rank_counter #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned RANK_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              adv_i,
  output logic [RANK_W-1:0] cnt_o
);

  localparam logic [RANK_W-1:0] CNT_MAX = RANK_W'(N_LINES - 1);

  logic [RANK_W-1:0] cnt_q, cnt_d;
  logic              at_max;
  logic              cnt_en;

  always_comb begin
    at_max = (cnt_q == CNT_MAX);
    cnt_en = clear_i | (adv_i & ~at_max);
    if (clear_i) cnt_d = '0;
    else         cnt_d = cnt_q + RANK_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + RANK_W'(1)));

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !adv_i) |=> $stable(cnt_q));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

endmodule

// File: rtl/rank_cell.sv
module rank_cell #(
  parameter int unsigned RANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              rise_i,
  input  logic [RANK_W-1:0] cnt_i,
  output logic              capture_o,
  output logic [RANK_W-1:0] rank_o,
  output logic              valid_o
);

  logic [RANK_W-1:0] rank_q, rank_d;
  logic              valid_q, valid_d;
  logic              cell_en;

  // Capture only on a fresh edge of an unranked line, never during a clear.
  always_comb begin
    capture_o = rise_i & ~valid_q & ~clear_i;
    cell_en   = clear_i | capture_o;
    if (clear_i) begin
      rank_d  = '0;
      valid_d = 1'b0;
    end else begin
      rank_d  = cnt_i;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rank_q  <= '0;
      valid_q <= 1'b0;
    end else if (cell_en) begin
      rank_q  <= rank_d;
      valid_q <= valid_d;
    end
  end

  assign rank_o  = rank_q;
  assign valid_o = valid_q;

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !valid_q && !clear_i) |=> (valid_q && rank_q == $past(cnt_i)));

  assert_write_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !clear_i) |=> (valid_q && $stable(rank_q)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!valid_q && rank_q == '0));

endmodule

// File: rtl/rank_recorder.sv
module rank_recorder #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned RANK_W  = rank_rec_pkg::rank_width(N_LINES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [N_LINES-1:0]        sw_i,
  output logic [N_LINES*RANK_W-1:0] rank_o,
  output logic [N_LINES-1:0]        valid_o,
  output logic                      all_ranked_o
);

  logic [N_LINES-1:0] rise;
  logic [N_LINES-1:0] capture;
  logic [RANK_W-1:0]  cnt;
  logic               any_capture;

  rank_line_sync #(.N_LINES(N_LINES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_i),
    .line_i  (sw_i),
    .rise_o  (rise)
  );

  assign any_capture = |capture;

  rank_counter #(.N_LINES(N_LINES), .RANK_W(RANK_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_i),
    .adv_i   (any_capture),
    .cnt_o   (cnt)
  );

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : g_cell
      rank_cell #(.RANK_W(RANK_W)) u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .rise_i    (rise[g]),
        .cnt_i     (cnt),
        .capture_o (capture[g]),
        .rank_o    (rank_o[g*RANK_W +: RANK_W]),
        .valid_o   (valid_o[g])
      );
    end
  endgenerate

  assign all_ranked_o = &valid_o;

  // Lines captured in the same cycle end up with equal ranks.
  assert_tie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (capture[0] && capture[N_LINES-1]) |=>
      (rank_o[0 +: RANK_W] == rank_o[(N_LINES-1)*RANK_W +: RANK_W]));

  assert_start_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o == '0 && !all_ranked_o));

  // Each newly ranked line leaves the counter one step further (until saturation).
  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_capture && cnt != RANK_W'(N_LINES - 1)) |=> cnt == $past(cnt) + RANK_W'(1));

endmodule

// File: tb/rank_recorder_bench.sv
module rank_recorder_bench;

  localparam int N = 8;
  localparam int W = 3;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [N-1:0]     sw_i;
  logic [N*W-1:0]   rank_o;
  logic [N-1:0]     valid_o;
  logic             all_ranked_o;

  int checks;
  int fails;

  rank_recorder #(.N_LINES(N)) u_rank_recorder (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .sw_i         (sw_i),
    .rank_o       (rank_o),
    .valid_o      (valid_o),
    .all_ranked_o (all_ranked_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural reference: delayed line samples, dense rank counter.
  bit m_p1 [N];
  bit m_p2 [N];
  bit m_p3 [N];
  bit m_val[N];
  int m_rank[N];
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_p1[i] = 0; m_p2[i] = 0; m_p3[i] = 0; m_val[i] = 0; m_rank[i] = 0;
      end
      m_cnt = 0;
    end else begin
      bit any;
      any = 0;
      if (start_i) begin
        m_cnt = 0;
        for (int i = 0; i < N; i++) begin m_val[i] = 0; m_rank[i] = 0; end
      end else begin
        for (int i = 0; i < N; i++) begin
          if (m_p2[i] && !m_p3[i] && !m_val[i]) begin
            m_val[i] = 1; m_rank[i] = m_cnt; any = 1;
          end
        end
        if (any && m_cnt < N - 1) m_cnt = m_cnt + 1;
      end
      for (int i = 0; i < N; i++) begin
        m_p3[i] = start_i ? 0 : m_p2[i];
        m_p2[i] = m_p1[i];
        m_p1[i] = sw_i[i];
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    bit all;
    all = 1;
    for (int i = 0; i < N; i++) begin
      chk($sformatf("R2 valid line %0d", i), int'(valid_o[i]), int'(m_val[i]));
      chk($sformatf("R4 rank line %0d", i), int'(rank_o[i*W +: W]), m_rank[i]);
      all = all & m_val[i];
    end
    chk("R7 all_ranked", int'(all_ranked_o), int'(all));
  endtask

  task automatic tick(input logic st, input logic [N-1:0] sw);
    @(negedge clk);
    compare_all();
    start_i = st;
    sw_i    = sw;
  endtask

  function automatic int rank_of(input int i);
    return int'(rank_o[i*W +: W]);
  endfunction

  logic [N-1:0] cur;

  initial begin
    checks  = 0;
    fails   = 0;
    rst_n   = 1'b0;
    start_i = 1'b0;
    sw_i    = '0;
    cur     = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(valid_o), 0);
    chk("R1 ranks in reset", int'(rank_o), 0);
    chk("R1 all_ranked in reset", int'(all_ranked_o), 0);
    rst_n = 1'b1;
    repeat (3) tick(1'b0, cur);
    chk("R1 valid after reset", int'(valid_o), 0);

    // Scrambled single switches, ties, glitch on a ranked line.
    tick(1'b1, cur); repeat (2) tick(1'b0, cur);
    cur[3] = 1'b1; tick(1'b0, cur); repeat (3) tick(1'b0, cur);
    cur[0] = 1'b1; tick(1'b0, cur); repeat (3) tick(1'b0, cur);
    cur[1] = 1'b1; cur[2] = 1'b1; tick(1'b0, cur); repeat (3) tick(1'b0, cur);
    cur[7] = 1'b1; tick(1'b0, cur); repeat (3) tick(1'b0, cur);
    cur[3] = 1'b0; tick(1'b0, cur); repeat (2) tick(1'b0, cur);
    cur[3] = 1'b1; tick(1'b0, cur); repeat (3) tick(1'b0, cur);
    chk("R5 glitch keeps rank of line 3", rank_of(3), 0);
    cur[4] = 1'b1; tick(1'b0, cur); repeat (3) tick(1'b0, cur);
    chk("R7 not all ranked yet", int'(all_ranked_o), 0);
    cur[5] = 1'b1; cur[6] = 1'b1; tick(1'b0, cur); repeat (3) tick(1'b0, cur);
    chk("R2 first switch rank 0", rank_of(3), 0);
    chk("R3 second switch rank 1", rank_of(0), 1);
    chk("R4 tie line 1", rank_of(1), 2);
    chk("R4 tie line 2", rank_of(2), 2);
    chk("R4 rank after tie", rank_of(7), 3);
    chk("R5 counter not advanced by glitch", rank_of(4), 4);
    chk("R4 second tie line 5", rank_of(5), 5);
    chk("R4 second tie line 6", rank_of(6), 5);
    chk("R7 all ranked", int'(all_ranked_o), 1);

    // Start with all lines already high.
    tick(1'b1, cur);
    tick(1'b0, cur);
    chk("R6 start clears valid", int'(valid_o), 0);
    chk("R6 start clears ranks", int'(rank_o), 0);
    tick(1'b0, cur);
    chk("R6 held lines ranked after start", int'(valid_o), 255);
    chk("R6 held lines share rank 0", int'(rank_o), 0);

    // Falling lines capture nothing; a one-cycle pulse is a switch.
    cur = '0; tick(1'b0, cur); repeat (3) tick(1'b0, cur);
    tick(1'b1, cur); repeat (2) tick(1'b0, cur);
    tick(1'b0, 8'h04); tick(1'b0, 8'h00); repeat (3) tick(1'b0, 8'h00);
    chk("R2 pulse captured alone", int'(valid_o), 4);
    chk("R2 pulse rank", rank_of(2), 0);
    repeat (2) tick(1'b0, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule